// File: doc/BRIEF.md
# Instruction Sequencer with Hardware Interrupt Cycle

This block is the timing and control core of a small accumulator machine. A step counter feeds a decoder that produces one-hot timing lines. Alongside the counter, a phase state machine fetches each instruction word from a synchronous memory and decodes its opcode into one-hot lines. When the operand is indirect, it also resolves the effective address. At the right step it raises an execute strobe for the memory-operand group, the register-operate group or the device group. The execution unit sits outside the block. It ends each instruction by asserting a clear request, and the counter then returns to step 0.

When interrupts are enabled and a device flag is raised outside the three fetch steps, the block sets an interrupt-pending flip-flop. The next three steps then form a hardware cycle instead of a fetch. This cycle saves the program counter at address 0 and points the program counter at address 1. It also disables interrupts. The block drives the memory address from the next value of its address register. Because of this, a synchronous memory returns the addressed word in the following cycle.

The phase states and their transitions are as follows:
- PH_FETCH_ADDR goes to PH_FETCH_READ.
- PH_FETCH_READ goes to PH_DECODE.
- PH_DECODE goes to PH_RESOLVE.
- From PH_RESOLVE the machine goes to PH_STOPPED when the instruction is a halt. On a clear request it goes to the start phase. Otherwise it goes to PH_EXECUTE.
- PH_EXECUTE goes to the start phase on a clear request or when the counter wraps. Otherwise it stays in PH_EXECUTE.
- The start phase is PH_INT_SAVE when an interrupt is pending and PH_FETCH_ADDR otherwise.
- PH_INT_SAVE goes to PH_INT_WRITE, then to PH_INT_VECTOR, then to PH_FETCH_ADDR.
- PH_STOPPED holds until reset.

Top module: `instr_sequencer`

## Requirements
- R1: After reset the program counter is 0, timing line 0 is the only active timing line, the interrupt flip-flop and the interrupt enable are 0, and `running` is 1.
- R2: While running, exactly one timing line is active. The counter advances by one on each clock without a clear request. From step 15 it wraps to step 0 and starts a new fetch.
- R3: At step 0 the address register takes the program counter. At step 1 the instruction register takes the memory word and the program counter increments. At step 2 the address register takes instruction bits 11..0. Instruction bit 15 drives `indirect`, and bits 14..12 select one line of `op_dec` (bit k for opcode k).
- R4: At step 3, for an opcode other than 7 with bit 15 set, the address register takes bits 11..0 of the memory word read at the address field. A direct operand leaves it unchanged. `mr_exec` pulses at step 4 for every opcode other than 7.
- R5: At step 3, opcode 7 with bit 15 clear pulses `rr_exec` and opcode 7 with bit 15 set pulses `io_exec`, each for one cycle.
- R6: `sc_clr` is obeyed only from step 3 onward of a normal instruction, returning the counter to step 0 at the next edge. It is ignored during the fetch steps and the interrupt steps.
- R7: The interrupt flip-flop is set only when the counter is at step 3 or later, the interrupt enable is 1, and `flag_in` or `flag_out` is 1. It never sets during fetch steps, and never while the interrupt enable is 0.
- R8: In the interrupt cycle, step 0 clears the address register and saves the program counter in a temporary register. Step 1 clears the program counter. Step 2 increments it to 1 and clears the counter and the interrupt flip-flop, so that the next fetch reads address 1.
- R9: A device-group strobe with instruction bit 7 set sets the interrupt enable. With bit 6 set (and bit 7 clear), it clears the interrupt enable. Step 2 of the interrupt cycle also clears the interrupt enable.
- R10: A register-operate instruction with bit 0 set stops the machine. `running` drops to 0, all timing lines go to 0, and the program counter, strobes and memory write stay frozen until reset.
- R11: `mem_we` is asserted only at step 1 of the interrupt cycle, with `mem_addr` 0 and `mem_wdata` equal to the saved program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 16 | Word read from memory, valid one cycle after its address |
| mem_addr | output | 12 | Memory address (next address-register value) |
| mem_wdata | output | 16 | Memory write data (saved program counter) |
| mem_we | output | 1 | Memory write strobe |
| sc_clr | input | 1 | Request from the execution unit to return to step 0 |
| flag_in | input | 1 | Input device ready flag |
| flag_out | input | 1 | Output device ready flag |
| pc | output | 12 | Program counter |
| ar | output | 12 | Address register |
| ir | output | 16 | Instruction register |
| op_dec | output | 8 | One-hot decoded opcode |
| indirect | output | 1 | Indirect bit of the current instruction |
| timing | output | 16 | One-hot timing lines |
| mr_exec | output | 1 | Memory-operand execute strobe (step 4) |
| rr_exec | output | 1 | Register-operate execute strobe (step 3) |
| io_exec | output | 1 | Device-group execute strobe (step 3) |
| ien | output | 1 | Interrupt enable |
| int_cycle | output | 1 | Interrupt flip-flop |
| running | output | 1 | Machine is running (not halted) |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 16-bit word, a 4-bit step counter and a 3-bit opcode. With a 4-bit counter, a full wrap from step 15 back into a fetch takes only sixteen cycles. The bench therefore checks the wrap directly, together with the rule that a clear request is ignored during the fetch steps. The 16-bit word places the indirect, enable, disable and halt bits at the positions the requirements name. This lets short hand-written programs reach the indirect reload, both device-group edits of the interrupt enable, the halt, and a complete interrupt cycle.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

    typedef enum logic [3:0] {
        PH_FETCH_ADDR,
        PH_FETCH_READ,
        PH_DECODE,
        PH_RESOLVE,
        PH_EXECUTE,
        PH_INT_SAVE,
        PH_INT_WRITE,
        PH_INT_VECTOR,
        PH_STOPPED
    } phase_t;

endpackage

// File: rtl/seq_step_counter.sv
`timescale 1ns/1ps
module seq_step_counter #(
    parameter int SCW = 4,
    localparam int NT = 1 << SCW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           clr_i,
    output logic [SCW-1:0] sc_o,
    output logic [NT-1:0]  t_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_o <= '0;
        end else if (clr_i) begin
            sc_o <= '0;
        end else if (en_i) begin
            sc_o <= sc_o + 1'b1;
        end
    end

    for (genvar i = 0; i < NT; i++) begin : g_tline
        assign t_o[i] = en_i && (sc_o == SCW'(i));
    end

endmodule

// File: rtl/seq_op_decoder.sv
`timescale 1ns/1ps
module seq_op_decoder #(
    parameter int OPW = 3,
    localparam int ND = 1 << OPW
) (
    input  logic [OPW-1:0] op_i,
    output logic [ND-1:0]  d_o
);

    for (genvar k = 0; k < ND; k++) begin : g_dline
        assign d_o[k] = (op_i == OPW'(k));
    end

endmodule

// File: rtl/seq_intr_ctrl.sv
`timescale 1ns/1ps
module seq_intr_ctrl #(
    parameter int SCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic [SCW-1:0] sc_i,
    input  logic           fg_in_i,
    input  logic           fg_out_i,
    input  logic           io_go_i,
    input  logic           ion_i,
    input  logic           iof_i,
    input  logic           vec_done_i,
    output logic           r_o,
    output logic           r_next_o,
    output logic           ien_o
);

    logic r_set;
    logic ien_d;

    // request may only latch outside the three fetch steps
    assign r_set = run_i && !r_o && ien_o && (fg_in_i || fg_out_i)
                   && (sc_i > SCW'(2));

    always_comb begin
        r_next_o = vec_done_i ? 1'b0 : (r_o || r_set);
        ien_d    = ien_o;
        if (vec_done_i) begin
            ien_d = 1'b0;
        end else if (io_go_i && ion_i) begin
            ien_d = 1'b1;
        end else if (io_go_i && iof_i) begin
            ien_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_o   <= 1'b0;
            ien_o <= 1'b0;
        end else begin
            r_o   <= r_next_o;
            ien_o <= ien_d;
        end
    end

    assert_r_outside_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_o) |-> ($past(sc_i) > SCW'(2)) && $past(ien_o));

    assert_ien_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_done_i |=> !ien_o && !r_o);

endmodule

// File: rtl/instr_sequencer.sv
`timescale 1ns/1ps
module instr_sequencer #(
    parameter int AW  = 12,
    parameter int DW  = 16,
    parameter int SCW = 4,
    parameter int OPW = 3,
    localparam int ND = 1 << OPW,
    localparam int NT = 1 << SCW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic          sc_clr,
    input  logic          flag_in,
    input  logic          flag_out,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] ar,
    output logic [DW-1:0] ir,
    output logic [ND-1:0] op_dec,
    output logic          indirect,
    output logic [NT-1:0] timing,
    output logic          mr_exec,
    output logic          rr_exec,
    output logic          io_exec,
    output logic          ien,
    output logic          int_cycle,
    output logic          running
);
    import seq_pkg::*;

    localparam int IND_BIT = DW - 1;
    localparam int OP_LSB  = DW - 1 - OPW;
    localparam int ION_BIT = 7;
    localparam int IOF_BIT = 6;
    localparam int HLT_BIT = 0;
    localparam logic [SCW-1:0] MR_STEP = SCW'(4);
    localparam logic [SCW-1:0] SC_LAST = {SCW{1'b1}};

    phase_t ph_q, ph_d, start_ph;

    logic [AW-1:0]  ar_q, ar_d, pc_q, pc_d;
    logic [DW-1:0]  ir_q, ir_d, tr_q, tr_d;
    logic [SCW-1:0] sc_q;
    logic           run, sc_clear, halt_now, vec_done;
    logic           mr_go, rr_go, io_go, we;
    logic           reg_op, r_q, r_next, ien_q;

    assign run    = (ph_q != PH_STOPPED);
    assign reg_op = op_dec[ND-1];

    seq_step_counter #(.SCW(SCW)) u_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (run),
        .clr_i (sc_clear),
        .sc_o  (sc_q),
        .t_o   (timing)
    );

    seq_op_decoder #(.OPW(OPW)) u_opdec (
        .op_i (ir_q[OP_LSB +: OPW]),
        .d_o  (op_dec)
    );

    seq_intr_ctrl #(.SCW(SCW)) u_intr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .sc_i       (sc_q),
        .fg_in_i    (flag_in),
        .fg_out_i   (flag_out),
        .io_go_i    (io_go),
        .ion_i      (ir_q[ION_BIT]),
        .iof_i      (ir_q[IOF_BIT]),
        .vec_done_i (vec_done),
        .r_o        (r_q),
        .r_next_o   (r_next),
        .ien_o      (ien_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_FETCH_ADDR;
        end else begin
            ph_q <= ph_d;
        end
    end

    // next phase
    always_comb begin
        start_ph = r_next ? PH_INT_SAVE : PH_FETCH_ADDR;
        ph_d     = ph_q;
        unique case (ph_q)
            PH_FETCH_ADDR: ph_d = PH_FETCH_READ;
            PH_FETCH_READ: ph_d = PH_DECODE;
            PH_DECODE:     ph_d = PH_RESOLVE;
            PH_RESOLVE: begin
                if (halt_now)    ph_d = PH_STOPPED;
                else if (sc_clr) ph_d = start_ph;
                else             ph_d = PH_EXECUTE;
            end
            PH_EXECUTE: begin
                if (sc_clr || sc_q == SC_LAST) ph_d = start_ph;
            end
            PH_INT_SAVE:   ph_d = PH_INT_WRITE;
            PH_INT_WRITE:  ph_d = PH_INT_VECTOR;
            PH_INT_VECTOR: ph_d = PH_FETCH_ADDR;
            PH_STOPPED:    ph_d = PH_STOPPED;
            default:       ph_d = PH_FETCH_ADDR;
        endcase
    end

    // per-phase register transfers and strobes
    always_comb begin
        ar_d     = ar_q;
        pc_d     = pc_q;
        ir_d     = ir_q;
        tr_d     = tr_q;
        we       = 1'b0;
        mr_go    = 1'b0;
        rr_go    = 1'b0;
        io_go    = 1'b0;
        halt_now = 1'b0;
        vec_done = 1'b0;
        sc_clear = 1'b0;
        unique case (ph_q)
            PH_FETCH_ADDR: ar_d = pc_q;
            PH_FETCH_READ: begin
                ir_d = mem_rdata;
                pc_d = pc_q + 1'b1;
            end
            PH_DECODE: ar_d = ir_q[AW-1:0];
            PH_RESOLVE: begin
                if (reg_op) begin
                    io_go    = ir_q[IND_BIT];
                    rr_go    = !ir_q[IND_BIT];
                    halt_now = !ir_q[IND_BIT] && ir_q[HLT_BIT];
                end else if (ir_q[IND_BIT]) begin
                    ar_d = mem_rdata[AW-1:0];
                end
                sc_clear = sc_clr || halt_now;
            end
            PH_EXECUTE: begin
                mr_go    = !reg_op && (sc_q == MR_STEP);
                sc_clear = sc_clr;
            end
            PH_INT_SAVE: begin
                ar_d = '0;
                tr_d = DW'(pc_q);
            end
            PH_INT_WRITE: begin
                we   = 1'b1;
                pc_d = '0;
            end
            PH_INT_VECTOR: begin
                pc_d     = pc_q + 1'b1;
                vec_done = 1'b1;
                sc_clear = 1'b1;
            end
            PH_STOPPED: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_q <= '0;
            pc_q <= '0;
            ir_q <= '0;
            tr_q <= '0;
        end else begin
            ar_q <= ar_d;
            pc_q <= pc_d;
            ir_q <= ir_d;
            tr_q <= tr_d;
        end
    end

    assign mem_addr  = ar_d;
    assign mem_wdata = tr_q;
    assign mem_we    = we;
    assign pc        = pc_q;
    assign ar        = ar_q;
    assign ir        = ir_q;
    assign indirect  = ir_q[IND_BIT];
    assign mr_exec   = mr_go;
    assign rr_exec   = rr_go;
    assign io_exec   = io_go;
    assign ien       = ien_q;
    assign int_cycle = r_q;
    assign running   = run;

    assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_EXECUTE && !sc_clr && sc_q != SC_LAST)
        |=> timing == ($past(timing) << 1));

    assert_fetch_no_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_FETCH_ADDR) |=> (ph_q == PH_FETCH_READ) && timing[1]);

    assert_indirect_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RESOLVE && !reg_op && ir_q[IND_BIT])
        |=> ar_q == $past(mem_rdata[AW-1:0]));

    assert_vector_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_INT_VECTOR) |=> (pc_q == AW'(1)) && (ph_q == PH_FETCH_ADDR));

    assert_halt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_STOPPED) |=> $stable(pc_q) && (ph_q == PH_STOPPED) && (timing == '0));

    assert_write_at_rt1_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> r_q && timing[1] && (mem_addr == '0));

endmodule

// File: tb/test_instr_sequencer.sv
`timescale 1ns/1ps
module test_instr_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic        sc_clr;
    logic        flag_in = 1'b0;
    logic        flag_out = 1'b0;
    logic [11:0] pc, ar;
    logic [15:0] ir;
    logic [7:0]  op_dec;
    logic        indirect;
    logic [15:0] timing;
    logic        mr_exec, rr_exec, io_exec, ien, int_cycle, running;

    logic        auto_clr = 1'b1;
    logic        man_clr = 1'b0;
    logic        done = 1'b0;
    int          nvec = 0;
    int          nmis = 0;
    logic [15:0] mem [0:63];

    always #5 clk = ~clk;

    // execution-unit stand-in: finishes each strobed instruction at once
    assign sc_clr = auto_clr ? (mr_exec | rr_exec | io_exec) : man_clr;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[5:0]];
    end

    instr_sequencer i_instr_sequencer (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .sc_clr(sc_clr),
        .flag_in(flag_in), .flag_out(flag_out), .pc(pc), .ar(ar), .ir(ir),
        .op_dec(op_dec), .indirect(indirect), .timing(timing),
        .mr_exec(mr_exec), .rr_exec(rr_exec), .io_exec(io_exec),
        .ien(ien), .int_cycle(int_cycle), .running(running)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic clear_mem();
        for (int a = 0; a < 64; a++) mem[a] = 16'hFFFF;
    endtask

    // ends at the first negedge after release (cycle 0)
    task automatic restart();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        clear_mem(); mem[0] = 16'h2010;
        restart();
        chk("R1 pc", pc, 0);
        chk("R1 timing", timing, 16'h0001);
        chk("R1 int_cycle", int_cycle, 0);
        chk("R1 ien", ien, 0);
        chk("R1 running", running, 1);
        chk("R3 mem_addr at T0", mem_addr, 0);
    endtask

    task automatic t_direct();
        clear_mem(); mem[0] = 16'h2010;
        restart();
        tick(2);
        chk("R3 ir", ir, 16'h2010);
        chk("R3 pc", pc, 1);
        chk("R3 op_dec", op_dec, 8'h04);
        chk("R3 indirect", indirect, 0);
        tick(1);
        chk("R3 ar", ar, 12'h010);
        chk("R4 mr_exec not at T3", mr_exec, 0);
        tick(1);
        chk("R4 direct ar kept", ar, 12'h010);
        chk("R4 mr_exec at T4", mr_exec, 1);
        chk("R2 timing T4", timing, 16'h0010);
        tick(1);
        chk("R6 back to T0", timing, 16'h0001);
        chk("R3 next fetch addr", mem_addr, 12'h001);
    endtask

    task automatic t_indirect();
        clear_mem(); mem[0] = 16'hB020; mem[32] = 16'h0ABC;
        restart();
        tick(2);
        chk("R3 op_dec D3", op_dec, 8'h08);
        chk("R3 indirect", indirect, 1);
        tick(1);
        chk("R4 ar pointer", ar, 12'h020);
        tick(1);
        chk("R4 ar reloaded", ar, 12'hABC);
        chk("R4 mr_exec", mr_exec, 1);
    endtask

    task automatic t_rr_io();
        clear_mem(); mem[0] = 16'h7020; mem[1] = 16'hF080; mem[2] = 16'hF040;
        restart();
        tick(3);
        chk("R5 rr_exec", rr_exec, 1);
        chk("R5 io_exec idle", io_exec, 0);
        chk("R5 mr_exec idle", mr_exec, 0);
        tick(1);
        chk("R6 T0 after rr", timing, 16'h0001);
        tick(3);
        chk("R5 io_exec", io_exec, 1);
        chk("R5 rr_exec idle", rr_exec, 0);
        chk("R9 ien before", ien, 0);
        tick(1);
        chk("R9 ien set by bit7", ien, 1);
        tick(3);
        chk("R5 io_exec second", io_exec, 1);
        tick(1);
        chk("R9 ien cleared by bit6", ien, 0);
    endtask

    task automatic t_clr_ignored();
        clear_mem(); mem[0] = 16'h2010;
        auto_clr = 1'b0; man_clr = 1'b1;
        restart();
        tick(1);
        chk("R6 T1 despite clear", timing, 16'h0002);
        tick(1);
        chk("R6 T2 despite clear", timing, 16'h0004);
        tick(1);
        chk("R6 T3 reached", timing, 16'h0008);
        tick(1);
        chk("R6 clear obeyed at T3", timing, 16'h0001);
        chk("R6 pc", pc, 1);
        man_clr = 1'b0;
        tick(1);
        chk("R6 fetch resumes", timing, 16'h0002);
        auto_clr = 1'b1;
    endtask

    task automatic t_wrap();
        clear_mem(); mem[0] = 16'h2010; mem[1] = 16'h2010;
        auto_clr = 1'b0; man_clr = 1'b0; flag_in = 1'b1;
        restart();
        tick(15);
        chk("R2 step 15", timing, 16'h8000);
        chk("R7 no int with ien 0", int_cycle, 0);
        tick(1);
        chk("R2 wrap to T0", timing, 16'h0001);
        tick(2);
        chk("R2 fetch after wrap", pc, 2);
        chk("R7 still no int", int_cycle, 0);
        flag_in = 1'b0; auto_clr = 1'b1;
    endtask

    task automatic t_intr();
        clear_mem(); mem[0] = 16'hF080; mem[1] = 16'h2030;
        restart();
        tick(4);
        chk("R9 ien on", ien, 1);
        flag_out = 1'b1;
        tick(2);
        chk("R7 not set during fetch", int_cycle, 0);
        tick(1);
        chk("R7 not yet at T3", int_cycle, 0);
        tick(1);
        chk("R7 set after T3", int_cycle, 1);
        chk("R4 mr_exec", mr_exec, 1);
        tick(1);
        chk("R8 RT0 timing", timing, 16'h0001);
        chk("R8 RT0 addr 0", mem_addr, 0);
        chk("R11 no write at RT0", mem_we, 0);
        chk("R8 pc before save", pc, 2);
        tick(1);
        chk("R11 write at RT1", mem_we, 1);
        chk("R11 write addr", mem_addr, 0);
        chk("R11 write data", mem_wdata, 16'h0002);
        tick(1);
        chk("R8 pc cleared", pc, 0);
        chk("R11 no write at RT2", mem_we, 0);
        tick(1);
        chk("R8 pc vector", pc, 1);
        chk("R8 r cleared", int_cycle, 0);
        chk("R9 ien cleared", ien, 0);
        chk("R8 fetch from 1", mem_addr, 1);
        chk("R11 saved word", mem[0], 16'h0002);
        flag_out = 1'b0;
    endtask

    task automatic t_halt();
        clear_mem(); mem[0] = 16'h7001;
        restart();
        tick(3);
        chk("R10 rr strobe", rr_exec, 1);
        tick(1);
        chk("R10 running low", running, 0);
        chk("R10 timing idle", timing, 0);
        chk("R10 pc", pc, 1);
        tick(4);
        chk("R10 still stopped", running, 0);
        chk("R10 pc frozen", pc, 1);
        chk("R10 no write", mem_we, 0);
        chk("R10 no strobe", {mr_exec, rr_exec, io_exec}, 0);
    endtask

    initial begin
        clear_mem();
        t_reset();
        t_direct();
        t_indirect();
        t_rr_io();
        t_clr_ignored();
        t_wrap();
        t_intr();
        t_halt();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            nvec++; nmis++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

endmodule